// File: doc/BRIEF.md
# Prioritized Interrupt Level Selector

This block decides which numbered interrupt level, if any, should be presented to a processor core as a pending hardware interrupt. It combines a vector of externally driven level requests with the level bits held in a software-interrupt register. It then compares the combined set against the core's current priority threshold. From the highest level still eligible it forms a trap index. Two timer-match bits in the software-interrupt register do not name a level of their own. Either one, when set, requests level 14.

Three conditions override the normal selection. A pending vectored interrupt outranks every level interrupt and freezes the outputs. Clearing the global enable withdraws a raised request. If the core is already servicing an external-interrupt trap of higher index at a nonzero trap level, the selector does not replace the index with a lower one. Every signal here is a control or status pin, so there is no valid/ready handshake: inputs are sampled on every rising edge and both outputs are registers.

Top module: `lvlsel_top`

## Requirements
- R1: The pending set is the external level vector ORed with software-interrupt bits 15..1. Software bit 0 and bit 16 never stand for a level directly.
- R2: If software-interrupt bit 0 (tick match) or bit 16 (system-tick match) is set, level 14 counts as pending.
- R3: While `vec_pend` is 1, `irq_req` and `irq_idx` keep their values on the next edge, whatever the other inputs do.
- R4: If no pending level is strictly above `cur_pri`, a raised request is dropped and `irq_idx` becomes 0.
- R5: With `int_en` = 1, the winning level is the highest pending level strictly above `cur_pri`.
- R6: The index loaded for winning level n is 0x40 | n, and `irq_req` is 1 whenever such an index is loaded.
- R7: While `trap_lvl` is nonzero, `trap_type & 0x1F0` equals 0x40 and `trap_type` exceeds the new index, the outputs are left unchanged.
- R8: With `int_en` = 0 and a level above the threshold pending, a raised request is dropped and `irq_idx` becomes 0. If no request is raised, both outputs stay 0.
- R9: The outputs are rewritten only when the new index differs from the held one. When they are equal, the request and index stay as they are.
- R10: Both outputs are registered and take their new values on the first rising edge after the inputs change. A synchronous active-high `rst` sets both to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_lvl | input | 16 | External interrupt level requests, bit n = level n |
| soft_int | input | 17 | Software-interrupt register; bit 0 tick match, bit 16 system-tick match |
| cur_pri | input | 4 | Current processor priority threshold |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| trap_type | input | 9 | Trap type currently being serviced |
| vec_pend | input | 1 | A vectored interrupt is pending |
| irq_req | output | 1 | Registered interrupt request to the core |
| irq_idx | output | 9 | Registered trap index of the requested level |

## Verification
Every result of this selector appears exactly one rising edge after the inputs that cause it, because one register stage follows the merge, scan and guard logic. The bench changes inputs only on falling edges. It compares the outputs on the next falling edge, which puts one rising edge between stimulus and sample. For the hold cases (vectored pending, nested guard, unchanged index), the outputs are sampled again after the changed inputs have had that edge to take effect. This shows that the edge left the outputs untouched.

// File: rtl/lvlsel_pkg.sv
package lvlsel_pkg;
  localparam int LVL_N     = 16;
  localparam int PRI_W     = $clog2(LVL_N);
  localparam int SOFT_W    = 17;
  localparam int TICK_BIT  = 0;
  localparam int STICK_BIT = 16;
  localparam int FOLD_LVL  = 14;
  localparam int TT_W      = 9;
  localparam int TL_W      = 3;
  localparam logic [TT_W-1:0] EXT_BASE   = 9'h040;
  localparam logic [TT_W-1:0] GROUP_MASK = 9'h1F0;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_LOAD  = 2'd2
  } lvl_act_e;
endpackage

// File: rtl/lvlsel_merge.sv
module lvlsel_merge
  import lvlsel_pkg::*;
#(
  parameter int NLVL  = LVL_N,
  parameter int SW    = SOFT_W,
  parameter int TBIT  = TICK_BIT,
  parameter int SBIT  = STICK_BIT,
  parameter int FLVL  = FOLD_LVL
) (
  input  logic [NLVL-1:0] ext_lvl,
  input  logic [SW-1:0]   soft_int,
  output logic [NLVL-1:0] pend
);
  logic [SW-1:0]   soft_lvls;
  logic            timer_hit;
  logic [NLVL-1:0] fold_vec;

  always_comb begin
    soft_lvls       = soft_int;
    soft_lvls[TBIT] = 1'b0;
    soft_lvls[SBIT] = 1'b0;
  end

  assign timer_hit = soft_int[TBIT] | soft_int[SBIT];

  generate
    for (genvar g = 0; g < NLVL; g++) begin : g_fold
      if (g == FLVL) begin : g_on
        assign fold_vec[g] = timer_hit;
      end else begin : g_off
        assign fold_vec[g] = 1'b0;
      end
    end
  endgenerate

  assign pend = ext_lvl | soft_lvls[NLVL-1:0] | fold_vec;
endmodule

// File: rtl/lvlsel_scan.sv
module lvlsel_scan
  import lvlsel_pkg::*;
#(
  parameter int NLVL = LVL_N,
  parameter int PW   = PRI_W
) (
  input  logic [NLVL-1:0] pend,
  input  logic [PW-1:0]   cur_pri,
  output logic            hit,
  output logic [PW-1:0]   win_lvl
);
  logic [NLVL-1:0] above;
  logic [NLVL-1:0] elig;

  generate
    for (genvar g = 0; g < NLVL; g++) begin : g_above
      assign above[g] = (g > int'(cur_pri));
    end
  endgenerate

  assign elig = pend & above;
  assign hit  = |elig;

  always_comb begin
    win_lvl = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (elig[i]) win_lvl = PW'(i);
    end
  end
endmodule

// File: rtl/lvlsel_guard.sv
module lvlsel_guard
  import lvlsel_pkg::*;
#(
  parameter int TTW = TT_W,
  parameter int TLW = TL_W
) (
  input  logic [TLW-1:0] trap_lvl,
  input  logic [TTW-1:0] trap_type,
  input  logic [TTW-1:0] new_idx,
  output logic           block
);
  logic nested, in_group, higher;

  assign nested   = (trap_lvl != '0);
  assign in_group = ((trap_type & GROUP_MASK) == EXT_BASE);
  assign higher   = (trap_type > new_idx);
  assign block    = nested & in_group & higher;
endmodule

// File: rtl/lvlsel_top.sv
module lvlsel_top
  import lvlsel_pkg::*;
#(
  parameter int NLVL = LVL_N,
  parameter int SW   = SOFT_W,
  parameter int TTW  = TT_W,
  parameter int TLW  = TL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLVL-1:0]  ext_lvl,
  input  logic [SW-1:0]    soft_int,
  input  logic [$clog2(NLVL)-1:0] cur_pri,
  input  logic             int_en,
  input  logic [TLW-1:0]   trap_lvl,
  input  logic [TTW-1:0]   trap_type,
  input  logic             vec_pend,
  output logic             irq_req,
  output logic [TTW-1:0]   irq_idx
);
  localparam int PW = $clog2(NLVL);

  logic [NLVL-1:0] pend;
  logic            hit;
  logic [PW-1:0]   win_lvl;
  logic [TTW-1:0]  new_idx;
  logic            block;
  lvl_act_e        act;
  logic            req_q;
  logic [TTW-1:0]  idx_q;

  lvlsel_merge #(.NLVL(NLVL), .SW(SW)) merge_i (
    .ext_lvl (ext_lvl),
    .soft_int(soft_int),
    .pend    (pend)
  );

  lvlsel_scan #(.NLVL(NLVL), .PW(PW)) scan_i (
    .pend   (pend),
    .cur_pri(cur_pri),
    .hit    (hit),
    .win_lvl(win_lvl)
  );

  assign new_idx = EXT_BASE | TTW'(win_lvl);

  lvlsel_guard #(.TTW(TTW), .TLW(TLW)) guard_i (
    .trap_lvl (trap_lvl),
    .trap_type(trap_type),
    .new_idx  (new_idx),
    .block    (block)
  );

  // Decision: a vectored interrupt freezes everything; below threshold or
  // disabled withdraws a raised request; otherwise load a changed index.
  always_comb begin
    act = ACT_HOLD;
    if (!vec_pend) begin
      if (!hit) begin
        if (req_q) act = ACT_CLEAR;
      end else if (int_en) begin
        if (!block && (idx_q != new_idx)) act = ACT_LOAD;
      end else if (req_q) begin
        act = ACT_CLEAR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      idx_q <= '0;
    end else begin
      case (act)
        ACT_CLEAR: begin
          req_q <= 1'b0;
          idx_q <= '0;
        end
        ACT_LOAD: begin
          req_q <= 1'b1;
          idx_q <= new_idx;
        end
        default: ;
      endcase
    end
  end

  assign irq_req = req_q;
  assign irq_idx = idx_q;
endmodule

// File: rtl/lvlsel_chk.sv
module lvlsel_chk
  import lvlsel_pkg::*;
#(
  parameter int NLVL = LVL_N,
  parameter int SW   = SOFT_W,
  parameter int TTW  = TT_W
) (
  input logic            clk,
  input logic            rst,
  input logic [NLVL-1:0] ext_lvl,
  input logic [SW-1:0]   soft_int,
  input logic            int_en,
  input logic            vec_pend,
  input logic            irq_req,
  input logic [TTW-1:0]  irq_idx
);
  assert_vec_freeze_R3: assert property (@(posedge clk) disable iff (rst)
    vec_pend |=> ($stable(irq_req) && $stable(irq_idx)));

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_idx == '0));

  assert_nothing_pending_R4: assert property (@(posedge clk) disable iff (rst)
    (!vec_pend && (ext_lvl == '0) && (soft_int == '0)) |=> !irq_req);

  assert_index_group_R6: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (((irq_idx & GROUP_MASK) == EXT_BASE) && (irq_idx[3:0] != 4'd0)));

  assert_disable_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (!vec_pend && !int_en) |=> !irq_req);

  assert_rise_enabled_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> ($past(int_en) && !$past(vec_pend)));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!irq_req && (irq_idx == '0)));
endmodule

bind lvlsel_top lvlsel_chk #(.NLVL(NLVL), .SW(SW), .TTW(TTW)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .ext_lvl (ext_lvl),
  .soft_int(soft_int),
  .int_en  (int_en),
  .vec_pend(vec_pend),
  .irq_req (irq_req),
  .irq_idx (irq_idx)
);

// File: tb/lvlsel_top_tb.sv
module lvlsel_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] ext_lvl;
  logic [16:0] soft_int;
  logic [3:0]  cur_pri;
  logic        int_en;
  logic [2:0]  trap_lvl;
  logic [8:0]  trap_type;
  logic        vec_pend;
  logic        irq_req;
  logic [8:0]  irq_idx;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvlsel_top dut_i (
    .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .soft_int(soft_int),
    .cur_pri(cur_pri), .int_en(int_en), .trap_lvl(trap_lvl),
    .trap_type(trap_type), .vec_pend(vec_pend),
    .irq_req(irq_req), .irq_idx(irq_idx)
  );

  task automatic check(input string req, input logic exp_req, input logic [8:0] exp_idx);
    total++;
    if (irq_req !== exp_req || irq_idx !== exp_idx) begin
      bad++;
      $display("FAIL %s: got req=%0b idx=0x%03h, expected req=%0b idx=0x%03h",
               req, irq_req, irq_idx, exp_req, exp_idx);
    end
  endtask

  // Apply inputs after a falling edge, then sample at the next falling edge.
  task automatic drive(input logic [15:0] e, input logic [16:0] s, input logic [3:0] p,
                       input logic en, input logic [2:0] tl, input logic [8:0] tt,
                       input logic vp);
    ext_lvl = e; soft_int = s; cur_pri = p; int_en = en;
    trap_lvl = tl; trap_type = tt; vec_pend = vp;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ext_lvl = '0; soft_int = '0; cur_pri = '0; int_en = 1'b0;
    trap_lvl = '0; trap_type = '0; vec_pend = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 reset", 1'b0, 9'h000);
    // Drive a pending level during reset: outputs must stay cleared.
    rst = 1'b1;
    drive(16'h0020, '0, 4'd0, 1'b1, '0, '0, 1'b0);
    check("R10 reset dominates", 1'b0, 9'h000);
    rst = 1'b0;
  endtask

  task automatic t_basic();
    do_reset();
    drive(16'h0020, '0, 4'd0, 1'b1, '0, '0, 1'b0);
    check("R6 level 5 index", 1'b1, 9'h045);
    drive(16'h1208, '0, 4'd0, 1'b1, '0, '0, 1'b0);
    check("R5 highest of 3,9,12", 1'b1, 9'h04C);
    drive(16'h1208, '0, 4'd0, 1'b1, '0, '0, 1'b0);
    check("R9 same index held", 1'b1, 9'h04C);
  endtask

  task automatic t_threshold();
    do_reset();
    drive(16'h2000, '0, 4'd12, 1'b1, '0, '0, 1'b0);
    check("R5 level 13 above pri 12", 1'b1, 9'h04D);
    drive(16'h1000, '0, 4'd12, 1'b1, '0, '0, 1'b0);
    check("R4 level equal to pri dropped", 1'b0, 9'h000);
    drive(16'hFFFF, '0, 4'd15, 1'b1, '0, '0, 1'b0);
    check("R4 pri 15 masks all", 1'b0, 9'h000);
    drive(16'h0001, '0, 4'd0, 1'b1, '0, '0, 1'b0);
    check("R5 level 0 never wins", 1'b0, 9'h000);
  endtask

  task automatic t_soft();
    do_reset();
    drive('0, 17'h00080, 4'd0, 1'b1, '0, '0, 1'b0);
    check("R1 soft bit 7", 1'b1, 9'h047);
    drive('0, 17'h00001, 4'd0, 1'b1, '0, '0, 1'b0);
    check("R2 tick bit to level 14", 1'b1, 9'h04E);
    drive('0, '0, 4'd0, 1'b1, '0, '0, 1'b0);
    check("R4 cleared when empty", 1'b0, 9'h000);
    drive('0, 17'h10000, 4'd0, 1'b1, '0, '0, 1'b0);
    check("R2 stick bit to level 14", 1'b1, 9'h04E);
    drive('0, 17'h10001, 4'd14, 1'b1, '0, '0, 1'b0);
    check("R1 timer bits are not levels 0/16", 1'b0, 9'h000);
    drive(16'h0004, 17'h08000, 4'd0, 1'b1, '0, '0, 1'b0);
    check("R1 soft bit 15 beats ext 2", 1'b1, 9'h04F);
  endtask

  task automatic t_vector();
    do_reset();
    drive(16'h0020, '0, 4'd0, 1'b1, '0, '0, 1'b0);
    check("R6 setup", 1'b1, 9'h045);
    drive(16'h0400, '0, 4'd0, 1'b1, '0, '0, 1'b1);
    check("R3 vec holds on new level", 1'b1, 9'h045);
    drive(16'h0400, '0, 4'd0, 1'b0, '0, '0, 1'b1);
    check("R3 vec holds when disabled", 1'b1, 9'h045);
    drive(16'h0000, '0, 4'd0, 1'b1, '0, '0, 1'b1);
    check("R3 vec holds when empty", 1'b1, 9'h045);
    drive(16'h0400, '0, 4'd0, 1'b1, '0, '0, 1'b0);
    check("R3 released updates", 1'b1, 9'h04A);
  endtask

  task automatic t_disable();
    do_reset();
    drive(16'h0100, '0, 4'd0, 1'b0, '0, '0, 1'b0);
    check("R8 disabled never raises", 1'b0, 9'h000);
    drive(16'h0100, '0, 4'd0, 1'b1, '0, '0, 1'b0);
    check("R6 level 8", 1'b1, 9'h048);
    drive(16'h0100, '0, 4'd0, 1'b0, '0, '0, 1'b0);
    check("R8 disable drops request", 1'b0, 9'h000);
  endtask

  task automatic t_guard();
    do_reset();
    drive(16'h0200, '0, 4'd0, 1'b1, 3'd1, 9'h04B, 1'b0);
    check("R7 higher ext trap blocks", 1'b0, 9'h000);
    drive(16'h0200, '0, 4'd0, 1'b1, 3'd0, 9'h04B, 1'b0);
    check("R7 trap level 0 no block", 1'b1, 9'h049);
    do_reset();
    drive(16'h0200, '0, 4'd0, 1'b1, 3'd2, 9'h048, 1'b0);
    check("R7 lower trap type no block", 1'b1, 9'h049);
    do_reset();
    drive(16'h0200, '0, 4'd0, 1'b1, 3'd1, 9'h060, 1'b0);
    check("R7 other group no block", 1'b1, 9'h049);
    drive(16'h0020, '0, 4'd0, 1'b1, 3'd1, 9'h04F, 1'b0);
    check("R7 held request kept", 1'b1, 9'h049);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    ext_lvl = '0; soft_int = '0; cur_pri = '0; int_en = 1'b0;
    trap_lvl = '0; trap_type = '0; vec_pend = 1'b0;
    t_reset();
    t_basic();
    t_threshold();
    t_soft();
    t_vector();
    t_disable();
    t_guard();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule